// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects interrupt requests from a set of on-chip peripheral sources. It resolves which pending source wins, and drives a single interrupt line to the processor. Each source carries a programmable 3-bit priority level, a recognition mode (edge or level) and a 16-bit vector table offset. A source competes only while its level is strictly above the current priority threshold held in the mask register.

Resolution is performed by a small internal sequencer over a fixed window of clock cycles. When a window closes with a qualifying winner, the winner's offset, index and level are captured and the processor line is raised. The handler then reads the vector register to acknowledge the interrupt. That read raises the threshold to the accepted level, clears the accepted source if it is edge-recognized, drops the processor line and starts a fresh resolution. A write to the mask register also drops the line and starts a fresh resolution, even when it writes back the value just read. Software forms the handler pointer address by zero-extending the 16-bit vector value.

Top module: `vpic_ctrl`

## Requirements
- R1: `vec_q` resets to 0. When a request is accepted, it captures the 16-bit offset of the winning source and holds that value until the next acceptance.
- R2: A `vec_rd` pulse without a simultaneous `mask_wr` loads `mask_q` with the priority level of the last accepted source on the following cycle.
- R3: A `vec_rd` pulse clears the pending flag of the last accepted source if that source is edge-recognized (`cfg_edge`=1). A level-recognized source (`cfg_edge`=0) keeps requesting for as long as its input stays high.
- R4: A `vec_rd` pulse makes `cpu_irq` low on the following cycle.
- R5: Both `vec_rd` and `mask_wr` restart resolution. If a qualifying source is pending, `cpu_irq` rises on exactly the RES_CYCLES-th rising clock edge after the edge that sampled the restart.
- R6: A `mask_wr` pulse loads `mask_wdata` into `mask_q`, drops `cpu_irq` on the next cycle and restarts resolution. When `mask_wr` and `vec_rd` coincide, the written value takes precedence for the mask.
- R7: A source qualifies only if its 3-bit level (0..7, 7 highest) is strictly greater than `mask_q`. A source at level 0 never raises `cpu_irq`.
- R8: Among qualifying sources the highest level wins. Among equal levels the lowest source index wins.
- R9: An edge-recognized source latches a pending flag on a 0-to-1 transition of its input. A `cfg_we` write with `cfg_clr`=1 clears the selected source's pending flag. When a rising edge and a clear hit the same cycle, the flag is set.
- R10: After reset `mask_q` equals 7 when MASK_RST_ALL=1 (the default) and 0 otherwise, and `cpu_irq` is low.
- R11: A window that closes without a qualifying source starts the next window at once. A request that arrives while no interrupt is outstanding raises `cpu_irq` within two windows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | NUM_SRC | Raw request inputs, one per source |
| cfg_we | input | 1 | Write strobe for one source's control register |
| cfg_idx | input | IDX_W | Source selected by the control write |
| cfg_level | input | 3 | Priority level written (0 disables) |
| cfg_edge | input | 1 | Recognition mode written: 1 edge, 0 level |
| cfg_vec | input | 16 | Vector table offset written |
| cfg_clr | input | 1 | With cfg_we, clears the selected source's pending flag |
| vec_rd | input | 1 | Read strobe of the vector register (acknowledge) |
| vec_q | output | 16 | Vector register contents |
| mask_wr | input | 1 | Write strobe of the mask register |
| mask_wdata | input | 3 | Value written to the mask register |
| mask_q | output | 3 | Current priority threshold |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
The bench drives a simultaneous rising edge on one edge source and a held level on another at the same priority. This separates the tie-break by index from a tie-break by arrival. The acknowledge is followed by a write-back of the mask, so a cleared edge source and a still-asserted level source behave differently on the re-arbitration. A level-0 source and a source at exactly the threshold are pulsed to show that equality does not qualify. A clear that lands in the same cycle as a rising edge, and a mask write that coincides with an acknowledge, pin down the two precedence rules. A behavioural model is compared against all three outputs on every cycle, so an off-by-one in the resolution window shows up as a cycle mismatch.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  localparam int LVL_W = 3;
  localparam int VEC_W = 16;

  typedef struct packed {
    logic [LVL_W-1:0] level;
    logic             edge_mode;
    logic [VEC_W-1:0] vec;
  } src_cfg_t;
endpackage

// File: rtl/vpic_src_bank.sv
module vpic_src_bank
  import vpic_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        irq_src,
  input  logic                      cfg_we,
  input  logic [IDX_W-1:0]          cfg_idx,
  input  logic [LVL_W-1:0]          cfg_level,
  input  logic                      cfg_edge,
  input  logic [VEC_W-1:0]          cfg_vec,
  input  logic                      cfg_clr,
  input  logic                      ack_clr,
  input  logic [IDX_W-1:0]          ack_idx,
  output logic [NUM_SRC-1:0]        req_o,
  output src_cfg_t [NUM_SRC-1:0]    cfg_o
);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic     in_q;
    logic     pend_q, pend_d;
    src_cfg_t cfg_q, cfg_d;
    logic     sel, clr, rise;

    always_comb begin
      sel    = cfg_we && (cfg_idx == IDX_W'(g));
      clr    = (ack_clr && (ack_idx == IDX_W'(g))) || (sel && cfg_clr);
      rise   = irq_src[g] && !in_q;
      pend_d = (pend_q && !clr) || (rise && cfg_q.edge_mode);
      cfg_d  = cfg_q;
      if (sel) begin
        cfg_d.level     = cfg_level;
        cfg_d.edge_mode = cfg_edge;
        cfg_d.vec       = cfg_vec;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        in_q   <= 1'b0;
        pend_q <= 1'b0;
        cfg_q  <= '0;
      end else begin
        in_q   <= irq_src[g];
        pend_q <= pend_d;
        cfg_q  <= cfg_d;
      end
    end

    assign req_o[g] = cfg_q.edge_mode ? pend_q : in_q;
    assign cfg_o[g] = cfg_q;
  end

endmodule

// File: rtl/vpic_arbiter.sv
module vpic_arbiter
  import vpic_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = 3
) (
  input  logic [NUM_SRC-1:0]     req_i,
  input  src_cfg_t [NUM_SRC-1:0] cfg_i,
  input  logic [LVL_W-1:0]       mask_i,
  output logic                   win_vld,
  output logic [IDX_W-1:0]       win_idx,
  output logic [LVL_W-1:0]       win_lvl,
  output logic [VEC_W-1:0]       win_vec
);

  // Strict compare while scanning upward keeps the lowest index on a tie.
  always_comb begin
    win_vld = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    win_vec = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req_i[i] && (cfg_i[i].level > mask_i) && (cfg_i[i].level > win_lvl)) begin
        win_vld = 1'b1;
        win_idx = IDX_W'(i);
        win_lvl = cfg_i[i].level;
        win_vec = cfg_i[i].vec;
      end
    end
  end

endmodule

// File: rtl/vpic_seq.sv
module vpic_seq #(
  parameter int RES_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic win_vld_i,
  output logic accept_o,
  output logic irq_o
);

  localparam int CNT_W = (RES_CYCLES > 1) ? $clog2(RES_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RES_CYCLES - 1);

  logic             hold_q, hold_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last;

  always_comb begin
    last     = (cnt_q == CNT_LAST);
    accept_o = !restart_i && !hold_q && last && win_vld_i;
    hold_d   = hold_q;
    cnt_d    = cnt_q;
    if (restart_i) begin
      hold_d = 1'b0;
      cnt_d  = '0;
    end else if (!hold_q) begin
      if (last) begin
        cnt_d  = '0;
        hold_d = win_vld_i;
      end else begin
        cnt_d  = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      hold_q <= hold_d;
      cnt_q  <= cnt_d;
    end
  end

  assign irq_o = hold_q;

endmodule

// File: rtl/vpic_ctrl.sv
module vpic_ctrl
  import vpic_pkg::*;
#(
  parameter int NUM_SRC      = 8,
  parameter int RES_CYCLES   = 4,
  parameter bit MASK_RST_ALL = 1'b1,
  localparam int IDX_W       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [LVL_W-1:0]   cfg_level,
  input  logic               cfg_edge,
  input  logic [VEC_W-1:0]   cfg_vec,
  input  logic               cfg_clr,
  input  logic               vec_rd,
  output logic [VEC_W-1:0]   vec_q,
  input  logic               mask_wr,
  input  logic [LVL_W-1:0]   mask_wdata,
  output logic [LVL_W-1:0]   mask_q,
  output logic               cpu_irq
);

  localparam logic [LVL_W-1:0] MASK_RST = MASK_RST_ALL ? '1 : '0;

  logic [NUM_SRC-1:0]     req;
  src_cfg_t [NUM_SRC-1:0] cfg;
  logic                   win_vld;
  logic [IDX_W-1:0]       win_idx;
  logic [LVL_W-1:0]       win_lvl;
  logic [VEC_W-1:0]       win_vec;
  logic                   accept;
  logic                   restart;

  logic [LVL_W-1:0] mask_r, mask_d;
  logic [VEC_W-1:0] vec_r, vec_d;
  logic [IDX_W-1:0] acc_idx_q, acc_idx_d;
  logic [LVL_W-1:0] acc_lvl_q, acc_lvl_d;

  assign restart = vec_rd || mask_wr;

  vpic_src_bank #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) bank_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_src  (irq_src),
    .cfg_we   (cfg_we),
    .cfg_idx  (cfg_idx),
    .cfg_level(cfg_level),
    .cfg_edge (cfg_edge),
    .cfg_vec  (cfg_vec),
    .cfg_clr  (cfg_clr),
    .ack_clr  (vec_rd),
    .ack_idx  (acc_idx_q),
    .req_o    (req),
    .cfg_o    (cfg)
  );

  vpic_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) arb_i (
    .req_i  (req),
    .cfg_i  (cfg),
    .mask_i (mask_r),
    .win_vld(win_vld),
    .win_idx(win_idx),
    .win_lvl(win_lvl),
    .win_vec(win_vec)
  );

  vpic_seq #(.RES_CYCLES(RES_CYCLES)) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart_i(restart),
    .win_vld_i(win_vld),
    .accept_o (accept),
    .irq_o    (cpu_irq)
  );

  always_comb begin
    mask_d    = mask_r;
    vec_d     = vec_r;
    acc_idx_d = acc_idx_q;
    acc_lvl_d = acc_lvl_q;
    if (mask_wr) begin
      mask_d = mask_wdata;
    end else if (vec_rd) begin
      mask_d = acc_lvl_q;
    end
    if (accept) begin
      vec_d     = win_vec;
      acc_idx_d = win_idx;
      acc_lvl_d = win_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_r    <= MASK_RST;
      vec_r     <= '0;
      acc_idx_q <= '0;
      acc_lvl_q <= '0;
    end else begin
      mask_r    <= mask_d;
      vec_r     <= vec_d;
      acc_idx_q <= acc_idx_d;
      acc_lvl_q <= acc_lvl_d;
    end
  end

  assign mask_q = mask_r;
  assign vec_q  = vec_r;

endmodule

// File: rtl/vpic_ctrl_chk.sv
module vpic_ctrl_chk
  import vpic_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             vec_rd,
  input logic             mask_wr,
  input logic [LVL_W-1:0] mask_wdata,
  input logic [LVL_W-1:0] mask_q,
  input logic [VEC_W-1:0] vec_q,
  input logic             cpu_irq,
  input logic [LVL_W-1:0] acc_lvl
);

  p_vec_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq && $past(cpu_irq)) |-> $stable(vec_q));

  p_mask_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && !mask_wr) |=> (mask_q == $past(acc_lvl)));

  p_irq_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_rd |=> !cpu_irq);

  p_mask_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> ((mask_q == $past(mask_wdata)) && !cpu_irq));

  p_above_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_irq) |-> (acc_lvl > mask_q));

endmodule

bind vpic_ctrl vpic_ctrl_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .vec_rd    (vec_rd),
  .mask_wr   (mask_wr),
  .mask_wdata(mask_wdata),
  .mask_q    (mask_q),
  .vec_q     (vec_q),
  .cpu_irq   (cpu_irq),
  .acc_lvl   (acc_lvl_q)
);

// File: tb/vpic_ctrl_tb_top.sv
module vpic_ctrl_tb_top;
  localparam int N  = 8;
  localparam int RC = 4;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_src = '0;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [2:0]    cfg_level = '0;
  logic          cfg_edge = 1'b0;
  logic [15:0]   cfg_vec = '0;
  logic          cfg_clr = 1'b0;
  logic          vec_rd = 1'b0;
  logic [15:0]   vec_q;
  logic          mask_wr = 1'b0;
  logic [2:0]    mask_wdata = '0;
  logic [2:0]    mask_q;
  logic          cpu_irq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  vpic_ctrl #(.NUM_SRC(N), .RES_CYCLES(RC), .MASK_RST_ALL(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_level(cfg_level),
    .cfg_edge(cfg_edge), .cfg_vec(cfg_vec), .cfg_clr(cfg_clr),
    .vec_rd(vec_rd), .vec_q(vec_q), .mask_wr(mask_wr),
    .mask_wdata(mask_wdata), .mask_q(mask_q), .cpu_irq(cpu_irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int  m_lvl [N];
  bit  m_edge[N];
  int  m_vec [N];
  bit  m_pend[N];
  bit  m_in  [N];
  int  m_mask, m_vecreg, m_acc_idx, m_acc_lvl, m_cnt;
  bit  m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_lvl[i] = 0; m_edge[i] = 0; m_vec[i] = 0; m_pend[i] = 0; m_in[i] = 0;
      end
      m_mask = 7; m_vecreg = 0; m_acc_idx = 0; m_acc_lvl = 0; m_cnt = 0; m_irq = 0;
    end else begin
      int best;
      int bl;
      bit rq;
      bit sel;
      best = -1; bl = 0;
      for (int i = 0; i < N; i++) begin
        rq = m_edge[i] ? m_pend[i] : m_in[i];
        if (rq && m_lvl[i] > m_mask && m_lvl[i] > bl) begin best = i; bl = m_lvl[i]; end
      end
      for (int i = 0; i < N; i++) begin
        sel = cfg_we && (int'(cfg_idx) == i);
        if ((vec_rd && m_acc_idx == i) || (sel && cfg_clr)) m_pend[i] = 0;
        if (m_edge[i] && irq_src[i] && !m_in[i]) m_pend[i] = 1;
        if (sel) begin
          m_lvl[i] = int'(cfg_level); m_edge[i] = cfg_edge; m_vec[i] = int'(cfg_vec);
        end
        m_in[i] = irq_src[i];
      end
      if (mask_wr) m_mask = int'(mask_wdata);
      else if (vec_rd) m_mask = m_acc_lvl;
      if (vec_rd || mask_wr) begin
        m_irq = 0; m_cnt = 0;
      end else if (!m_irq) begin
        if (m_cnt == RC - 1) begin
          m_cnt = 0;
          if (best >= 0) begin
            m_irq = 1; m_vecreg = m_vec[best]; m_acc_idx = best; m_acc_lvl = bl;
          end
        end else m_cnt++;
      end
    end
  end

  // Every-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(cpu_irq == m_irq, "R5 cpu_irq vs model", int'(cpu_irq), int'(m_irq));
      check(int'(vec_q) == m_vecreg, "R1 vec_q vs model", int'(vec_q), m_vecreg);
      check(int'(mask_q) == m_mask, "R2 mask_q vs model", int'(mask_q), m_mask);
    end
  end

  task automatic cfg_src(input int idx, input int lvl, input bit edg, input int vec, input bit clr);
    @(negedge clk);
    cfg_we = 1; cfg_idx = IW'(idx); cfg_level = 3'(lvl); cfg_edge = edg;
    cfg_vec = 16'(vec); cfg_clr = clr;
    @(negedge clk);
    cfg_we = 0; cfg_clr = 0;
  endtask

  task automatic wr_mask(input int v);
    @(negedge clk);
    mask_wr = 1; mask_wdata = 3'(v);
    @(negedge clk);
    mask_wr = 0;
  endtask

  task automatic rd_vec(output int v);
    @(negedge clk);
    v = int'(vec_q);
    vec_rd = 1;
    @(negedge clk);
    vec_rd = 0;
  endtask

  task automatic pulse(input logic [N-1:0] bits);
    @(negedge clk);
    irq_src = irq_src | bits;
    @(negedge clk);
    irq_src = irq_src & ~bits;
  endtask

  task automatic wait_irq(input int max, output int n);
    n = 0;
    while (!cpu_irq && n < max) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(mask_q == 3'd7, "R10 reset mask", int'(mask_q), 7);
    check(vec_q == 16'd0, "R1 reset vec", int'(vec_q), 0);
    check(cpu_irq == 1'b0, "R10 reset irq", int'(cpu_irq), 0);

    cfg_src(0, 3, 1, 'h1000, 0);
    cfg_src(1, 5, 1, 'h1100, 0);
    cfg_src(2, 5, 0, 'h1200, 0);
    cfg_src(3, 0, 1, 'h1300, 0);
    wr_mask(0);
    check(mask_q == 3'd0, "R6 mask written", int'(mask_q), 0);

    // simultaneous edge on 1, held level on 2, edge on level-0 source 3
    @(negedge clk);
    irq_src = 8'b0000_1110;
    @(negedge clk);
    irq_src = 8'b0000_0100;
    wait_irq(3 * RC, n);
    check(cpu_irq == 1'b1, "R11 request raised", int'(cpu_irq), 1);
    check(vec_q == 16'h1100, "R8 tie lowest index", int'(vec_q), 'h1100);
    rd_vec(v);
    check(v == 'h1100, "R1 vector read", v, 'h1100);
    check(cpu_irq == 1'b0, "R4 irq dropped", int'(cpu_irq), 0);
    check(mask_q == 3'd5, "R2 mask raised", int'(mask_q), 5);
    idle(3 * RC);
    check(cpu_irq == 1'b0, "R7 equal level masked", int'(cpu_irq), 0);

    wr_mask(0);
    wait_irq(3 * RC, n);
    check(n == RC, "R5 resolution cycles", n, RC);
    check(vec_q == 16'h1200, "R3 edge source cleared", int'(vec_q), 'h1200);
    rd_vec(v);
    wr_mask(0);
    wait_irq(3 * RC, n);
    check(vec_q == 16'h1200, "R3 level source stays", int'(vec_q), 'h1200);
    rd_vec(v);
    @(negedge clk);
    irq_src = '0;
    wr_mask(0);
    idle(3 * RC);
    check(cpu_irq == 1'b0, "R7 level zero never", int'(cpu_irq), 0);

    pulse(8'b0000_0001);
    wait_irq(3 * RC, n);
    check(vec_q == 16'h1000, "R11 scan picks new", int'(vec_q), 'h1000);
    rd_vec(v);
    check(mask_q == 3'd3, "R2 mask level 3", int'(mask_q), 3);

    // software clear of a pending edge
    wr_mask(7);
    pulse(8'b0000_0001);
    cfg_src(0, 3, 1, 'h1000, 1);
    wr_mask(0);
    idle(3 * RC);
    check(cpu_irq == 1'b0, "R9 pending cleared", int'(cpu_irq), 0);

    // rising edge and clear in the same cycle: set wins
    @(negedge clk);
    irq_src[0] = 1; cfg_we = 1; cfg_idx = 0; cfg_level = 3; cfg_edge = 1;
    cfg_vec = 16'h1000; cfg_clr = 1;
    @(negedge clk);
    irq_src[0] = 0; cfg_we = 0; cfg_clr = 0;
    wait_irq(3 * RC, n);
    check(cpu_irq == 1'b1, "R9 set beats clear", int'(cpu_irq), 1);

    // acknowledge and mask write together: written value wins
    @(negedge clk);
    vec_rd = 1; mask_wr = 1; mask_wdata = 3'd2;
    @(negedge clk);
    vec_rd = 0; mask_wr = 0;
    check(mask_q == 3'd2, "R6 write beats ack", int'(mask_q), 2);
    check(cpu_irq == 1'b0, "R6 irq dropped", int'(cpu_irq), 0);
    idle(3 * RC);
    check(vec_q == 16'h1000, "R1 vector held", int'(vec_q), 'h1000);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule